// File: doc/BRIEF.md
# Compact 16-bit Single-Cycle RISC Core

This block is a small processor that completes one 16-bit instruction on every falling clock edge. Each word carries a 4-bit operation code in bits 15-12 and three 4-bit fields below it. The core holds an 8-bit program counter and an instruction ROM of 256 words. The ROM is filled at elaboration from the `PROGRAM` parameter: word *i* sits at bits `16*i+15 : 16*i`, and any address at or beyond `PROG_LEN` reads as 0. The core also has sixteen 16-bit registers, of which register 0 always reads zero, an ALU, branch and jump logic, and a word-addressed data memory for loads and stores.

The core has no bus. Its only output is an observation port: a 3-bit select picks one of registers 0 to 7, and the port shows that register's current value. By convention these registers are named zero, t0 to t5, and sp, with t5 kept free for stack sequences. The external active-low reset acts at once. Its release is synchronised to the falling edge, and the program then starts at word 0.

Top module: `tiny_risc_core`

## Requirements
- R1: While `rst_n` is low, every register reads 0 and the program counter is 0. After `rst_n` rises, the second falling edge lets the core run, and word 0 executes on the third falling edge.
- R2: Register 0 always reads 0. Any instruction that names it as destination leaves it at 0.
- R3: The register operations are: opcode 0 and, 5 sub, 9 or, 10 add, 14 nor. Each reads its sources from bits 11-8 and 7-4 and writes its result to the register in bits 3-0.
- R4: The immediate operations are: opcode 1 andi and 11 ori, which zero-extend the 4-bit immediate, and opcode 7 addi and 6 subi, which sign-extend it. Each reads bits 11-8 and writes the register in bits 7-4. The immediate is bits 3-0.
- R5: Opcode 8 (shift left) and opcode 13 (logical shift right) shift the register in bits 11-8 by bits 3-0, fill with zeros, and write the register in bits 7-4.
- R6: Opcode 12 (load) writes the register in bits 7-4 with the memory word at address (register in bits 11-8 + sign-extended bits 3-0). Opcode 15 (store) writes the register in bits 7-4 to that same address.
- R7: Opcode 2 branches when the registers in bits 11-8 and 7-4 are equal, and opcode 4 branches when they differ. A taken branch sets PC to PC+1 plus the sign-extended bits 3-0. An untaken branch, and every non-jump instruction, sets PC to PC+1.
- R8: Opcode 3 loads bits 11-4 into the program counter as an absolute target.
- R9: `dbg_val` shows register `dbg_sel` (0 to 7) combinationally.
- R10: Registers, memory and the program counter change only on the falling clock edge. A rising edge changes nothing.
- R11: The sequence store to 0(sp), decrement sp, clobber, increment sp, load from 0(sp) restores the pushed value and returns sp to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state advances on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_sel | input | 3 | Selects register 0 to 7 for observation |
| dbg_val | output | 16 | Value of the selected register |

## Verification
A single test program runs through every opcode, and the bench checks registers at exact step counts after reset release, so wrong timing shows up as well as wrong values. The operands are chosen so that each variant gives a different result from its wrong twin:
- a negative immediate shows sign extension against zero extension;
- a shift of a negative value shows a logical shift against an arithmetic one;
- a negative load offset shows the address sum is signed.

A backward branch loop, taken and untaken branches, and jumps over trap instructions show the next-PC choice. A push/pop sequence and a reset in the middle of the run confirm that state is restored and that execution restarts from word 0.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,  OP_ANDI = 4'd1,  OP_BEQ  = 4'd2,  OP_JMP  = 4'd3,
    OP_BNE  = 4'd4,  OP_SUB  = 4'd5,  OP_SUBI = 4'd6,  OP_ADDI = 4'd7,
    OP_SLL  = 4'd8,  OP_OR   = 4'd9,  OP_ADD  = 4'd10, OP_ORI  = 4'd11,
    OP_LW   = 4'd12, OP_SRL  = 4'd13, OP_NOR  = 4'd14, OP_SW   = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SHL, ALU_SHR
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    use_imm;
    logic    imm_signed;
    logic    wr_en;
    logic    dst_mid;   // destination in bits 7-4 instead of 3-0
    logic    mem_rd;
    logic    mem_wr;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
  } ctrl_t;

endpackage

// File: rtl/trc_decode.sv
module trc_decode
  import trc_pkg::*;
(
  input  logic [3:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{fn: ALU_ADD, default: 1'b0};
    unique case (opcode_e'(opcode))
      OP_AND:  begin ctrl.fn = ALU_AND; ctrl.wr_en = 1'b1; end
      OP_OR:   begin ctrl.fn = ALU_OR;  ctrl.wr_en = 1'b1; end
      OP_NOR:  begin ctrl.fn = ALU_NOR; ctrl.wr_en = 1'b1; end
      OP_ADD:  begin ctrl.fn = ALU_ADD; ctrl.wr_en = 1'b1; end
      OP_SUB:  begin ctrl.fn = ALU_SUB; ctrl.wr_en = 1'b1; end
      OP_ANDI: begin ctrl.fn = ALU_AND; ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1; ctrl.dst_mid = 1'b1; end
      OP_ORI:  begin ctrl.fn = ALU_OR;  ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1; ctrl.dst_mid = 1'b1; end
      OP_ADDI: begin
        ctrl.fn = ALU_ADD; ctrl.use_imm = 1'b1; ctrl.imm_signed = 1'b1;
        ctrl.wr_en = 1'b1; ctrl.dst_mid = 1'b1;
      end
      OP_SUBI: begin
        ctrl.fn = ALU_SUB; ctrl.use_imm = 1'b1; ctrl.imm_signed = 1'b1;
        ctrl.wr_en = 1'b1; ctrl.dst_mid = 1'b1;
      end
      OP_SLL:  begin ctrl.fn = ALU_SHL; ctrl.wr_en = 1'b1; ctrl.dst_mid = 1'b1; end
      OP_SRL:  begin ctrl.fn = ALU_SHR; ctrl.wr_en = 1'b1; ctrl.dst_mid = 1'b1; end
      OP_LW: begin
        ctrl.fn = ALU_ADD; ctrl.use_imm = 1'b1; ctrl.imm_signed = 1'b1;
        ctrl.wr_en = 1'b1; ctrl.dst_mid = 1'b1; ctrl.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl.fn = ALU_ADD; ctrl.use_imm = 1'b1; ctrl.imm_signed = 1'b1;
        ctrl.mem_wr = 1'b1;
      end
      OP_BEQ:  ctrl.br_eq = 1'b1;
      OP_BNE:  ctrl.br_ne = 1'b1;
      OP_JMP:  ctrl.jump  = 1'b1;
      default: ctrl = '{fn: ALU_ADD, default: 1'b0};
    endcase
  end
endmodule

// File: rtl/trc_alu.sv
module trc_alu
  import trc_pkg::*;
#(
  parameter int W  = 16,
  parameter int SH_W = 4
) (
  input  alu_fn_e         fn,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SH_W-1:0] shamt,
  output logic [W-1:0]    y
);
  always_comb begin
    unique case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SHL: y = a << shamt;
      ALU_SHR: y = a >> shamt;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/trc_regfile.sv
module trc_regfile #(
  parameter int W     = 16,
  parameter int NREG  = 16,
  parameter int DBG_W = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra,
  input  logic [IDX_W-1:0] rb,
  output logic [W-1:0]     va,
  output logic [W-1:0]     vb,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [W-1:0]     wd,
  input  logic [DBG_W-1:0] dsel,
  output logic [W-1:0]     dval
);
  logic [W-1:0] bank_q [NREG];
  logic [W-1:0] bank_d [NREG];
  logic         wr_ok;

  // register 0 is never written
  assign wr_ok = we && (wa != '0);

  always_comb begin
    bank_d = bank_q;
    if (wr_ok) bank_d[wa] = wd;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (wr_ok) begin
      bank_q <= bank_d;
    end
  end

  function automatic logic [W-1:0] rd(input logic [IDX_W-1:0] idx);
    return (idx == '0) ? '0 : bank_q[idx];
  endfunction

  assign va   = rd(ra);
  assign vb   = rd(rb);
  assign dval = rd(IDX_W'(dsel));
endmodule

// File: rtl/trc_dmem.sv
module trc_dmem #(
  parameter int W  = 16,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(negedge clk) begin
    if (we) cells[addr] <= wd;
  end

  assign rd = cells[addr];
endmodule

// File: rtl/tiny_risc_core.sv
module tiny_risc_core
  import trc_pkg::*;
#(
  parameter int W        = 16,
  parameter int PC_W     = 8,
  parameter int NREG     = 16,
  parameter int DM_AW    = 6,
  parameter int DBG_W    = 3,
  parameter int PROG_LEN = 2,
  parameter logic [16*PROG_LEN-1:0] PROGRAM = {16'h3010, 16'h7011}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DBG_W-1:0] dbg_sel,
  output logic [W-1:0]     dbg_val
);
  localparam int IW    = 16;
  localparam int FLD   = 4;
  localparam int IDX_W = $clog2(NREG);

  // reset: asserted at once, released on the falling edge
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // program counter and instruction fetch
  logic [PC_W-1:0] pc_q, pc_d;
  logic [IW-1:0]   instr;

  always_comb begin
    if (int'(pc_q) < PROG_LEN) instr = PROGRAM[int'(pc_q)*IW +: IW];
    else                       instr = '0;
  end

  ctrl_t ctrl;
  trc_decode u_dec (.opcode(instr[15:12]), .ctrl(ctrl));

  logic [FLD-1:0] f_hi, f_mid, f_lo;
  assign f_hi  = instr[11:8];
  assign f_mid = instr[7:4];
  assign f_lo  = instr[3:0];

  logic [W-1:0] va, vb, wb_val, alu_y, imm_ext, alu_b, mem_q;
  logic [IDX_W-1:0] dst;
  logic rf_we, dm_we;

  assign dst   = ctrl.dst_mid ? IDX_W'(f_mid) : IDX_W'(f_lo);
  assign rf_we = ctrl.wr_en;
  assign dm_we = ctrl.mem_wr;

  trc_regfile #(.W(W), .NREG(NREG), .DBG_W(DBG_W)) u_rf (
    .clk(clk), .rst_n(core_rst_n),
    .ra(IDX_W'(f_hi)), .rb(IDX_W'(f_mid)), .va(va), .vb(vb),
    .we(rf_we), .wa(dst), .wd(wb_val),
    .dsel(dbg_sel), .dval(dbg_val)
  );

  assign imm_ext = ctrl.imm_signed ? {{(W-FLD){f_lo[FLD-1]}}, f_lo} : {{(W-FLD){1'b0}}, f_lo};
  assign alu_b   = ctrl.use_imm ? imm_ext : vb;

  trc_alu #(.W(W), .SH_W(FLD)) u_alu (
    .fn(ctrl.fn), .a(va), .b(alu_b), .shamt(f_lo), .y(alu_y)
  );

  trc_dmem #(.W(W), .AW(DM_AW)) u_dm (
    .clk(clk), .we(dm_we), .addr(alu_y[DM_AW-1:0]), .wd(vb), .rd(mem_q)
  );

  assign wb_val = ctrl.mem_rd ? mem_q : alu_y;

  // next program counter
  logic [PC_W-1:0] pc_inc, br_off;
  logic            taken;
  assign pc_inc = pc_q + PC_W'(1);
  assign br_off = {{(PC_W-FLD){f_lo[FLD-1]}}, f_lo};
  assign taken  = (ctrl.br_eq && (va == vb)) || (ctrl.br_ne && (va != vb));

  always_comb begin
    if (ctrl.jump)  pc_d = instr[11:4];
    else if (taken) pc_d = pc_inc + br_off;
    else            pc_d = pc_inc;
  end

  always_ff @(negedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
  parameter int W    = 16,
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc,
  input logic [15:0]     instr,
  input logic [W-1:0]    va,
  input logic [W-1:0]    vb,
  input logic [2:0]      dbg_sel,
  input logic [W-1:0]    dbg_val
);
  logic [3:0]      op;
  logic [PC_W-1:0] off;
  logic            ctl_flow;
  assign op       = instr[15:12];
  assign off      = {{(PC_W-4){instr[3]}}, instr[3:0]};
  assign ctl_flow = (op == 4'd2) || (op == 4'd3) || (op == 4'd4);

  p_zero_reads_r2: assert property (@(negedge clk) disable iff (!rst_n)
    (dbg_sel == 3'd0) |-> (dbg_val == '0));

  p_jump_abs_r8: assert property (@(negedge clk) disable iff (!rst_n)
    (op == 4'd3) |=> (pc == $past(instr[11:4])));

  p_seq_pc_r7: assert property (@(negedge clk) disable iff (!rst_n)
    !ctl_flow |=> (pc == $past(pc) + PC_W'(1)));

  p_br_taken_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (((op == 4'd2) && (va == vb)) || ((op == 4'd4) && (va != vb)))
      |=> (pc == $past(pc) + PC_W'(1) + $past(off)));

  p_br_fall_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (((op == 4'd2) && (va != vb)) || ((op == 4'd4) && (va == vb)))
      |=> (pc == $past(pc) + PC_W'(1)));
endmodule

bind tiny_risc_core trc_checker #(.W(W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(core_rst_n), .pc(pc_q), .instr(instr),
  .va(va), .vb(vb), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
);

// File: tb/tiny_risc_core_test.sv
module tiny_risc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int PN = 34;

  function automatic logic [15:0] enc(input int op, input int a, input int b, input int c);
    return {4'(op), 4'(a), 4'(b), 4'(c)};
  endfunction

  localparam logic [15:0] WORDS [PN] = '{
    enc(7,0,1,5),    // 0  addi r1,r0,5
    enc(7,0,2,13),   // 1  addi r2,r0,-3
    enc(10,1,2,3),   // 2  add r3,r1,r2
    enc(5,1,2,4),    // 3  sub r4,r1,r2
    enc(1,2,5,15),   // 4  andi r5,r2,15
    enc(8,1,6,12),   // 5  sll r6,r1,12
    enc(13,2,3,12),  // 6  srl r3,r2,12
    enc(9,5,6,4),    // 7  or r4,r5,r6
    enc(14,1,0,5),   // 8  nor r5,r1,r0
    enc(11,0,6,10),  // 9  ori r6,r0,10
    enc(6,1,3,15),   // 10 subi r3,r1,-1
    enc(7,0,0,7),    // 11 addi r0,r0,7
    enc(7,0,7,7),    // 12 addi sp,r0,7
    enc(15,7,4,0),   // 13 sw r4,0(sp)
    enc(6,7,7,1),    // 14 subi sp,sp,1
    enc(7,0,4,0),    // 15 addi r4,r0,0
    enc(7,7,7,1),    // 16 addi sp,sp,1
    enc(12,7,4,0),   // 17 lw r4,0(sp)
    enc(15,7,3,14),  // 18 sw r3,-2(sp)
    enc(12,7,5,14),  // 19 lw r5,-2(sp)
    enc(12,1,6,0),   // 20 lw r6,0(r1)
    enc(2,1,3,2),    // 21 beq r1,r3,+2 (not taken)
    enc(7,0,2,1),    // 22 addi r2,r0,1
    enc(4,1,3,2),    // 23 bneq r1,r3,+2 (taken)
    enc(7,0,2,7),    // 24 skipped
    enc(7,0,2,6),    // 25 skipped
    enc(7,2,2,1),    // 26 addi r2,r2,1
    enc(4,2,3,14),   // 27 bneq r2,r3,-2
    enc(2,0,0,1),    // 28 beq r0,r0,+1
    enc(7,0,2,1),    // 29 skipped
    enc(3,2,0,0),    // 30 j 32
    enc(7,0,2,0),    // 31 skipped
    enc(7,0,1,15),   // 32 addi r1,r0,-1
    enc(3,2,1,0)     // 33 j 33
  };

  function automatic logic [16*PN-1:0] pack_prog();
    logic [16*PN-1:0] r;
    for (int i = 0; i < PN; i++) r[16*i +: 16] = WORDS[i];
    return r;
  endfunction

  localparam logic [16*PN-1:0] PROG = pack_prog();

  typedef struct packed {
    logic [7:0]  step;
    logic [2:0]  sel;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  3'd1, 16'h0005, 4'd4},   // R4 addi
    '{8'd2,  3'd2, 16'hFFFD, 4'd4},   // R4 sign-extended
    '{8'd3,  3'd3, 16'h0002, 4'd3},   // R3 add
    '{8'd4,  3'd4, 16'h0008, 4'd3},   // R3 sub
    '{8'd5,  3'd5, 16'h000D, 4'd4},   // R4 andi zero-extended
    '{8'd6,  3'd6, 16'h5000, 4'd5},   // R5 sll
    '{8'd7,  3'd3, 16'h000F, 4'd5},   // R5 srl logical
    '{8'd8,  3'd4, 16'h500D, 4'd3},   // R3 or
    '{8'd9,  3'd5, 16'hFFFA, 4'd3},   // R3 nor
    '{8'd10, 3'd6, 16'h000A, 4'd4},   // R4 ori zero-extended
    '{8'd11, 3'd3, 16'h0006, 4'd4},   // R4 subi negative
    '{8'd12, 3'd0, 16'h0000, 4'd2},   // R2 write to r0 ignored
    '{8'd13, 3'd7, 16'h0007, 4'd9},   // R9 sp visible on select 7
    '{8'd15, 3'd7, 16'h0006, 4'd11},  // R11 sp decremented
    '{8'd16, 3'd4, 16'h0000, 4'd11},  // R11 clobbered
    '{8'd17, 3'd7, 16'h0007, 4'd11},  // R11 sp restored
    '{8'd18, 3'd4, 16'h500D, 4'd11},  // R11 popped value
    '{8'd20, 3'd5, 16'h0006, 4'd6},   // R6 negative offset
    '{8'd21, 3'd6, 16'h0006, 4'd6},   // R6 same word via other base
    '{8'd23, 3'd2, 16'h0001, 4'd7},   // R7 beq not taken
    '{8'd25, 3'd2, 16'h0002, 4'd7},   // R7 bneq taken skips
    '{8'd29, 3'd2, 16'h0004, 4'd7},   // R7 backward loop
    '{8'd34, 3'd2, 16'h0006, 4'd7},   // R7 loop exit
    '{8'd37, 3'd1, 16'hFFFF, 4'd8},   // R8 jump landed
    '{8'd40, 3'd2, 16'h0006, 4'd8},   // R8 skipped words untouched
    '{8'd40, 3'd1, 16'hFFFF, 4'd8}    // R8 self-jump holds
  };

  logic        clk = 1'b1;
  logic        rst_n;
  logic [2:0]  dbg_sel;
  logic [15:0] dbg_val;
  int checks = 0;
  int errors = 0;
  int step   = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny_risc_core #(.PROG_LEN(PN), .PROGRAM(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] s, input string tag, input logic [15:0] exp);
    dbg_sel = s;
    #1;
    check(tag, dbg_val, exp);
  endtask

  task automatic release_reset();
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    step = 0;
  endtask

  task automatic run_to(input int s);
    while (step < s) begin
      @(negedge clk); #2;
      step++;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    dbg_sel = '0;
    repeat (3) @(negedge clk);
    #2;
    for (int i = 0; i < 8; i++) peek(3'(i), "R1 reset clears register", 16'h0000);
    release_reset();
    @(posedge clk); #1;
    peek(3'd1, "R10 rising edge changes nothing", 16'h0000);
    for (int i = 0; i < NV; i++) begin
      run_to(int'(VECS[i].step));
      peek(VECS[i].sel, $sformatf("R%0d step %0d sel %0d", VECS[i].req,
           VECS[i].step, VECS[i].sel), VECS[i].exp);
    end
    // reset in mid-run: immediate clear, then restart from word 0
    rst_n = 1'b0;
    peek(3'd1, "R1 async clear mid-run", 16'h0000);
    peek(3'd7, "R1 async clear sp", 16'h0000);
    release_reset();
    peek(3'd1, "R1 held until third falling edge", 16'h0000);
    run_to(1);
    peek(3'd1, "R1 restart executes word 0", 16'h0005);
    peek(3'd2, "R1 word 1 not yet run", 16'h0000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule